// File: doc/BRIEF.md
# Strap-Configured Suspend / Output Pad Controller

This block owns a single shared pad. The pad works either as an active-low suspend request coming in from the board or as a general-purpose output, such as a backlight power switch. Two configuration straps decide the role. The block samples them once, on the first clock edge after the active-low reset is released, and keeps that role until the next reset.

In output mode the straps also set the pad's idle level. A single control bit in an 8-bit register then chooses how the pad is driven:

- A 1 in the control bit drives the strapped idle level.
- A 0 in the control bit drives the inverse of that level.

The control bit resets to 1, so the pad sits at its idle level until software writes the register.

In input mode the output driver stays off. The pad passes through a two-flop synchroniser and produces a suspend request for the power-management logic.

Top module: `gpo_pad_ctrl`

## Requirements
- R1: The straps are sampled on the first rising clock edge after `rst_n` goes high. Later strap changes have no effect on the pad role or the idle level until the next reset.
- R2: When strap bit 0 is 0 (strap values 00 and 10), the pad is an input. In that mode `pad_oe_o` is 0 and `pad_o` is 0.
- R3: Strap value 01 (bit 1 = 0, bit 0 = 1) makes the pad an output with idle level 0. After reset `pad_oe_o` = 1 and `pad_o` = 0.
- R4: Strap value 11 makes the pad an output with idle level 1. After reset `pad_oe_o` = 1 and `pad_o` = 1.
- R5: In output mode, the control bit chooses the drive:
  - A control bit of 1 drives the idle level on `pad_o`.
  - A control bit of 0 drives the inverse of the idle level.
  - A register write shows on `pad_o` after the next rising clock edge.
- R6: The control bit is bit 7 of the register. It resets to 1 and is loaded from `reg_wdata_i[7]` when `reg_we_i` is 1. `reg_rdata_o[7]` returns the stored bit in every mode, and bits 6..0 always read 0.
- R7: In input mode, `suspend_req_o` equals the inverse of `pad_i` as it was two rising edges earlier. In output mode `suspend_req_o` is 0.
- R8: While reset is asserted, and until the straps have been sampled, `pad_oe_o` and `suspend_req_o` are 0.
- R9: In input mode, register writes change neither `pad_oe_o` nor `pad_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset; the straps are sampled after its release |
| strap_i | input | 2 | Configuration straps: bit 0 selects output, bit 1 gives the idle level |
| pad_i | input | 1 | Level received from the pad |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data; only bit 7 is stored |
| reg_rdata_o | output | 8 | Register read data: control bit in bit 7, zeros elsewhere |
| pad_o | output | 1 | Value driven onto the pad |
| pad_oe_o | output | 1 | Pad output enable |
| suspend_req_o | output | 1 | Synchronised, active-high suspend request |

## Verification
The checker watches several rules on every cycle:
- The output enable never changes once the role is latched.
- An undriven pad carries 0.
- No suspend request is raised while the pad is driven.
- Read-back follows each write.
- A write that changes the control bit flips the driven level.
- The suspend request follows the pad with a two-cycle lag in input mode.

Only the directed scenarios can show other behaviour:
- Each strap value maps to the right role and idle level.
- Strap changes after sampling are ignored.
- Writes have no visible effect in input mode.
- The exact edge at which the suspend request rises and falls.

// File: rtl/gpo_pad_pkg.sv
package gpo_pad_pkg;

    // Synchroniser length on the pad input path
    localparam int SYNC_DEPTH = 2;

    // Latched pad role
    typedef struct packed {
        logic drive;     // 1: pad is an output
        logic idle_lvl;  // level driven while the control bit is 1
    } pin_cfg_t;

    // Bit 0 alone selects the output role; bit 1 only matters when driving
    function automatic pin_cfg_t decode_strap(input logic [1:0] s);
        pin_cfg_t c;
        c.drive    = s[0];
        c.idle_lvl = s[0] & s[1];
        return c;
    endfunction

endpackage

// File: rtl/strap_capture.sv
module strap_capture
    import gpo_pad_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] strap_i,
    output pin_cfg_t   cfg_o,
    output logic       latched_o
);

    typedef struct packed {
        logic     latched;
        pin_cfg_t cfg;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.latched) begin
            st_d.cfg     = decode_strap(strap_i);
            st_d.latched = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o     = st_q.cfg;
    assign latched_o = st_q.latched;

endmodule

// File: rtl/pad_sync.sv
module pad_sync #(
    parameter int   DEPTH     = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    typedef struct packed {
        logic [DEPTH-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain = {st_q.chain[DEPTH-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.chain <= {DEPTH{RESET_VAL}};
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.chain[DEPTH-1];

endmodule

// File: rtl/ctrl_reg.sv
module ctrl_reg #(
    parameter int DATA_W   = 8,
    parameter int CTRL_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic              wbit_i,
    output logic              ctrl_o,
    output logic [DATA_W-1:0] rdata_o
);

    typedef struct packed {
        logic ctrl;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.ctrl = wbit_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // Unused bit positions read as zero
    always_comb begin
        rdata_o           = '0;
        rdata_o[CTRL_BIT] = st_q.ctrl;
    end

    assign ctrl_o = st_q.ctrl;

endmodule

// File: rtl/gpo_pad_ctrl.sv
module gpo_pad_ctrl
    import gpo_pad_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int CTRL_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        strap_i,
    input  logic              pad_i,
    input  logic              reg_we_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              pad_o,
    output logic              pad_oe_o,
    output logic              suspend_req_o
);

    pin_cfg_t cfg;
    logic     cfg_latched;
    logic     ctrl_bit;
    logic     pad_sync_q;

    strap_capture u_strap (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_i   (strap_i),
        .cfg_o     (cfg),
        .latched_o (cfg_latched)
    );

    pad_sync #(
        .DEPTH     (SYNC_DEPTH),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pad_i),
        .q_o   (pad_sync_q)
    );

    ctrl_reg #(
        .DATA_W   (DATA_W),
        .CTRL_BIT (CTRL_BIT)
    ) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (reg_we_i),
        .wbit_i  (reg_wdata_i[CTRL_BIT]),
        .ctrl_o  (ctrl_bit),
        .rdata_o (reg_rdata_o)
    );

    logic drive_en;
    logic sense_en;

    always_comb begin
        drive_en      = cfg_latched & cfg.drive;
        sense_en      = cfg_latched & ~cfg.drive;
        pad_oe_o      = drive_en;
        // Control 1 keeps the idle level, control 0 inverts it
        pad_o         = drive_en & (cfg.idle_lvl ~^ ctrl_bit);
        suspend_req_o = sense_en & ~pad_sync_q;
    end

endmodule

// File: rtl/gpo_pad_ctrl_chk.sv
module gpo_pad_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic latched,
    input logic pad_i,
    input logic reg_we_i,
    input logic wr_ctrl,
    input logic rd_ctrl,
    input logic pad_o,
    input logic pad_oe_o,
    input logic suspend_req_o
);

    AST_ROLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && $past(latched)) |-> $stable(pad_oe_o)) // R1
        else $error("pad role changed after latching");

    AST_IDLE_PAD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_oe_o |-> !pad_o) // R2
        else $error("undriven pad carries 1");

    AST_WRITE_FLIPS_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(latched) && pad_oe_o && $past(pad_oe_o) && $past(reg_we_i)
         && ($past(wr_ctrl) != $past(rd_ctrl))) |-> (pad_o != $past(pad_o))) // R5
        else $error("control change did not flip pad");

    AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_we_i) |-> (rd_ctrl == $past(wr_ctrl))) // R6
        else $error("read-back mismatch");

    AST_NO_SUSPEND_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe_o |-> !suspend_req_o) // R7
        else $error("suspend request while driving");

    AST_SUSPEND_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && $past(latched) && $past(latched, 2) && !pad_oe_o)
        |-> (suspend_req_o == !$past(pad_i, 2))) // R7
        else $error("suspend request lag wrong");

    AST_QUIET_UNLATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        !latched |-> (!pad_oe_o && !suspend_req_o)) // R8
        else $error("activity before strap sampling");

endmodule

bind gpo_pad_ctrl gpo_pad_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .latched       (cfg_latched),
    .pad_i         (pad_i),
    .reg_we_i      (reg_we_i),
    .wr_ctrl       (reg_wdata_i[CTRL_BIT]),
    .rd_ctrl       (reg_rdata_o[CTRL_BIT]),
    .pad_o         (pad_o),
    .pad_oe_o      (pad_oe_o),
    .suspend_req_o (suspend_req_o)
);

// File: tb/gpo_pad_ctrl_tb.sv
`timescale 1ns/1ps
module gpo_pad_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] strap_i = 2'b01;
    logic       pad_i = 1'b1;
    logic       reg_we_i = 1'b0;
    logic [7:0] reg_wdata_i = 8'h00;
    logic [7:0] reg_rdata_o;
    logic       pad_o, pad_oe_o, suspend_req_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;  // 50 MHz

    gpo_pad_ctrl u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .strap_i       (strap_i),
        .pad_i         (pad_i),
        .reg_we_i      (reg_we_i),
        .reg_wdata_i   (reg_wdata_i),
        .reg_rdata_o   (reg_rdata_o),
        .pad_o         (pad_o),
        .pad_oe_o      (pad_oe_o),
        .suspend_req_o (suspend_req_o)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reset with given straps; returns at the negedge after strap sampling
    task automatic apply_reset(input logic [1:0] s);
        @(negedge clk);
        rst_n   = 1'b0;
        strap_i = s;
        pad_i   = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic write_reg(input logic [7:0] d);
        reg_we_i    = 1'b1;
        reg_wdata_i = d;
        @(negedge clk);
        reg_we_i = 1'b0;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        rst_n   = 1'b0;
        strap_i = 2'b01;
        pad_i   = 1'b0;
        @(negedge clk);
        check("R8", "oe in reset", {7'd0, pad_oe_o}, 8'h00);
        check("R8", "suspend in reset", {7'd0, suspend_req_o}, 8'h00);
        check("R6", "rdata reset", reg_rdata_o, 8'h80);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3", "oe after latch", {7'd0, pad_oe_o}, 8'h01);
        check("R3", "idle level", {7'd0, pad_o}, 8'h00);
    endtask

    task automatic t_output_low();
        apply_reset(2'b01);
        strap_i = 2'b00;  // ignored after sampling
        write_reg(8'h7F);
        check("R5", "inverted level", {7'd0, pad_o}, 8'h01);
        check("R6", "low bits read zero", reg_rdata_o, 8'h00);
        check("R1", "oe after strap change", {7'd0, pad_oe_o}, 8'h01);
        write_reg(8'h80);
        check("R5", "back to idle", {7'd0, pad_o}, 8'h00);
        check("R6", "readback", reg_rdata_o, 8'h80);
    endtask

    task automatic t_output_high();
        apply_reset(2'b11);
        check("R4", "oe", {7'd0, pad_oe_o}, 8'h01);
        check("R4", "idle level", {7'd0, pad_o}, 8'h01);
        strap_i = 2'b01;
        write_reg(8'h00);
        check("R5", "inverted level", {7'd0, pad_o}, 8'h00);
        check("R1", "idle kept after strap change", {7'd0, pad_oe_o}, 8'h01);
        pad_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R7", "no suspend while driving", {7'd0, suspend_req_o}, 8'h00);
    endtask

    task automatic t_input(input logic [1:0] s);
        apply_reset(s);
        check("R2", "oe in input mode", {7'd0, pad_oe_o}, 8'h00);
        check("R2", "pad_o in input mode", {7'd0, pad_o}, 8'h00);
        pad_i = 1'b0;
        @(negedge clk);
        check("R7", "suspend after one edge", {7'd0, suspend_req_o}, 8'h00);
        @(negedge clk);
        check("R7", "suspend after two edges", {7'd0, suspend_req_o}, 8'h01);
        write_reg(8'h00);
        check("R9", "oe after write", {7'd0, pad_oe_o}, 8'h00);
        check("R9", "pad_o after write", {7'd0, pad_o}, 8'h00);
        check("R6", "readback in input mode", reg_rdata_o, 8'h00);
        strap_i = 2'b01;
        pad_i   = 1'b1;
        @(negedge clk);
        check("R7", "release after one edge", {7'd0, suspend_req_o}, 8'h01);
        @(negedge clk);
        check("R7", "release after two edges", {7'd0, suspend_req_o}, 8'h00);
        check("R1", "role kept after strap change", {7'd0, pad_oe_o}, 8'h00);
    endtask

    initial begin
        t_reset_state();
        t_output_low();
        t_output_high();
        t_input(2'b00);
        t_input(2'b10);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule